// File: doc/BRIEF.md
# Host A20 Gate Sequence Decoder

This block sits beside the host-facing input buffer of a keyboard-controller-style peripheral. It watches every host write and handles the gate-A20 handshake in hardware, so the internal CPU is not involved. Each host write carries a register-select bit (command or data), a one-cycle write strobe and a data byte. The handshake is a D1h command followed by a data byte. Bit 1 of that data byte is copied straight to the A20 output pin. Writes that belong to the handshake never raise the input-buffer-full flag that would normally wake the CPU.

Decoding stays off until firmware pulses the enable input. After that it stays on until reset. While the decoder is off, every host write raises the input-buffer-full flag in the usual way, and the pin is left alone. A CPU read pulse clears the flag.

A small state machine tracks the handshake. It has three states: idle, armed (a D1h command has been seen) and complete (the data byte has been applied). In the complete state, one trailing FFh command is absorbed without raising the flag.

Top module: `a20_gate_seq`

## Requirements
- R1: After reset, `a20_q` is 1, `ibf_q` is 0 and the decoder is disabled.
- R2: While disabled, every host write (`wr_stb`=1) sets `ibf_q` on the next clock and leaves `a20_q` unchanged.
- R3: A one-cycle `en_set` pulse enables the decoder from the next clock onward. It stays enabled until reset, and further `en_set` pulses have no effect. A write in the same cycle as the pulse is handled as a disabled write.
- R4: When enabled, a command write (`wr_cmd`=1) of D1h followed by a data write (`wr_cmd`=0) loads `wr_data[1]` into `a20_q` on the clock that samples the data write. The other data bits are ignored. For example, DFh gives 1 and DDh gives 0.
- R5: When enabled, the D1h command write and the data write of a valid sequence do not set `ibf_q`.
- R6: An FFh command write that directly follows a completed sequence does not set `ibf_q`, leaves `a20_q` unchanged and returns the machine to idle. An FFh command written at any other time sets `ibf_q`.
- R7: Repeated D1h command writes keep the machine armed without setting `ibf_q`. The data write that finally follows still updates `a20_q`.
- R8: A command write other than D1h while armed sets `ibf_q`, leaves `a20_q` unchanged and returns to idle. A data write that follows it then sets `ibf_q` and does not touch `a20_q`.
- R9: A `cpu_rd` pulse clears `ibf_q` on the next clock. If a flag-raising write arrives in the same cycle, the flag ends up set.
- R10: When enabled, a data write in the idle state, and in the complete state, sets `ibf_q` and leaves `a20_q` unchanged. So does any command other than D1h or FFh in the complete state. In each case the machine returns to idle (or stays there).
- R11: `a20_q` changes only on the clock that samples the data write of a valid sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_set | input | 1 | One-cycle pulse that enables the decoder until reset |
| wr_stb | input | 1 | One-cycle host write strobe |
| wr_cmd | input | 1 | Register select of the write: 1 = command, 0 = data |
| wr_data | input | 8 | Host write byte |
| cpu_rd | input | 1 | CPU read pulse that clears the input-buffer-full flag |
| a20_q | output | 1 | A20 gate output pin |
| ibf_q | output | 1 | Input-buffer-full flag |

## Verification
The directed patterns each target one behaviour:
- Set and clear sequences with DFh and DDh show that only bit 1 of the data byte matters.
- The same sequence sent before and after enabling separates the disabled path from the enabled path.
- A trailing FFh right after a sequence, compared with a second FFh, separates the absorbed case from an ordinary command.
- A doubled D1h shows that re-arming is harmless.
- D1h followed by a foreign command shows that an aborted sequence raises the flag and leaves the pin alone.

A write that coincides with a CPU read exposes the set-over-clear priority. A reset in the middle of the run confirms that the enable does not survive reset. Constrained random writes, biased toward D1h, FFh, DFh and DDh, then mix all these orderings so that the state reached after each transition is covered.

// File: rtl/a20_gate_pkg.sv
package a20_gate_pkg;

   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_ARMED = 2'd1,
      SQ_DONE  = 2'd2
   } seq_st_t;

   typedef struct packed {
      logic    raise_ibf;
      logic    load_pin;
      seq_st_t nxt;
   } seq_dec_t;

endpackage

// File: rtl/a20_gate_enable.sv
module a20_gate_enable (
   input  logic clk,
   input  logic rst_n,
   input  logic en_set,
   output logic en_q
);

   always_ff @(posedge clk) begin
      if (!rst_n)      en_q <= 1'b0;
      else if (en_set) en_q <= 1'b1;
   end

   // R3: once set, the enable holds until reset
   p_en_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      en_q |=> en_q);
   p_en_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
      en_set |=> en_q);

endmodule

// File: rtl/a20_gate_fsm.sv
module a20_gate_fsm
   import a20_gate_pkg::*;
#(
   parameter int unsigned         DATA_W   = 8,
   parameter logic [DATA_W-1:0]   CMD_GATE = 8'hD1,
   parameter logic [DATA_W-1:0]   CMD_NOP  = 8'hFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_q,
   input  logic              wr_stb,
   input  logic              wr_cmd,
   input  logic [DATA_W-1:0] wr_data,
   output logic              raise_ibf,
   output logic              load_pin
);

   seq_st_t  st_q;
   seq_dec_t dec;
   logic     is_gate;
   logic     is_nop;

   assign is_gate = wr_cmd && (wr_data == CMD_GATE);
   assign is_nop  = wr_cmd && (wr_data == CMD_NOP);

   always_comb begin
      dec.raise_ibf = 1'b0;
      dec.load_pin  = 1'b0;
      dec.nxt       = st_q;
      if (wr_stb) begin
         if (!en_q) begin
            dec.raise_ibf = 1'b1;
            dec.nxt       = SQ_IDLE;
         end else begin
            unique case (st_q)
               SQ_ARMED: begin
                  if (is_gate) begin
                     dec.nxt = SQ_ARMED;
                  end else if (!wr_cmd) begin
                     dec.load_pin = 1'b1;
                     dec.nxt      = SQ_DONE;
                  end else begin
                     dec.raise_ibf = 1'b1;
                     dec.nxt       = SQ_IDLE;
                  end
               end
               SQ_DONE: begin
                  if (is_gate) begin
                     dec.nxt = SQ_ARMED;
                  end else if (is_nop) begin
                     dec.nxt = SQ_IDLE;
                  end else begin
                     dec.raise_ibf = 1'b1;
                     dec.nxt       = SQ_IDLE;
                  end
               end
               default: begin
                  if (is_gate) begin
                     dec.nxt = SQ_ARMED;
                  end else begin
                     dec.raise_ibf = 1'b1;
                     dec.nxt       = SQ_IDLE;
                  end
               end
            endcase
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= SQ_IDLE;
      else        st_q <= dec.nxt;
   end

   assign raise_ibf = dec.raise_ibf;
   assign load_pin  = dec.load_pin;

   // R2: a disabled decoder raises the flag on every write and never loads the pin
   p_disabled_raise_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && !en_q) |-> (raise_ibf && !load_pin));
   // R5 / R7: a D1h command is never flagged while enabled
   p_gate_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && en_q && is_gate) |-> !raise_ibf);
   // R11: the pin loads only from a data write, following a D1h command
   p_load_needs_arm_r11: assert property (@(posedge clk) disable iff (!rst_n)
      load_pin |-> (!wr_cmd && st_q == SQ_ARMED && en_q));
   // R6 / R10: the complete state always leaves on the next write
   p_done_exits_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && st_q == SQ_DONE) |=> (st_q != SQ_DONE));
   p_no_idle_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stb |-> (!raise_ibf && !load_pin));

endmodule

// File: rtl/a20_gate_ibf.sv
module a20_gate_ibf #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raise,
   input  logic clr,
   output logic ibf_q
);

   logic ibf_d;

   generate
      if (SET_WINS) begin : g_set_first
         always_comb begin
            if (raise)    ibf_d = 1'b1;
            else if (clr) ibf_d = 1'b0;
            else          ibf_d = ibf_q;
         end
      end else begin : g_clr_first
         always_comb begin
            if (clr)        ibf_d = 1'b0;
            else if (raise) ibf_d = 1'b1;
            else            ibf_d = ibf_q;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) ibf_q <= 1'b0;
      else        ibf_q <= ibf_d;
   end

   // R9: a read clears the flag unless a raise coincides
   p_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !raise) |=> !ibf_q);
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !raise) |=> $stable(ibf_q));

endmodule

// File: rtl/a20_gate_pin.sv
module a20_gate_pin #(
   parameter logic RST_LEVEL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic d,
   output logic q
);

   always_ff @(posedge clk) begin
      if (!rst_n)    q <= RST_LEVEL;
      else if (load) q <= d;
   end

   // R11: the pin moves only when loaded
   p_pin_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(q));
   // R4: a load copies the selected data bit
   p_pin_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (q == $past(d)));

endmodule

// File: rtl/a20_gate_seq.sv
module a20_gate_seq #(
   parameter int unsigned       DATA_W    = 8,
   parameter int unsigned       GATE_BIT  = 1,
   parameter logic [DATA_W-1:0] CMD_GATE  = 8'hD1,
   parameter logic [DATA_W-1:0] CMD_NOP   = 8'hFF,
   parameter logic              A20_RST   = 1'b1,
   parameter bit                SET_WINS  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_set,
   input  logic              wr_stb,
   input  logic              wr_cmd,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              cpu_rd,
   output logic              a20_q,
   output logic              ibf_q
);

   generate
      if (GATE_BIT >= DATA_W) begin : g_bad_bit
         $error("GATE_BIT must index inside the data byte");
      end
      if (CMD_GATE == CMD_NOP) begin : g_bad_cmd
         $error("gate and no-op command codes must differ");
      end
   endgenerate

   logic en_q;
   logic raise_ibf;
   logic load_pin;

   a20_gate_enable u_en (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_set (en_set),
      .en_q   (en_q)
   );

   a20_gate_fsm #(
      .DATA_W   (DATA_W),
      .CMD_GATE (CMD_GATE),
      .CMD_NOP  (CMD_NOP)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .en_q      (en_q),
      .wr_stb    (wr_stb),
      .wr_cmd    (wr_cmd),
      .wr_data   (wr_data),
      .raise_ibf (raise_ibf),
      .load_pin  (load_pin)
   );

   a20_gate_ibf #(
      .SET_WINS (SET_WINS)
   ) u_ibf (
      .clk   (clk),
      .rst_n (rst_n),
      .raise (raise_ibf),
      .clr   (cpu_rd),
      .ibf_q (ibf_q)
   );

   a20_gate_pin #(
      .RST_LEVEL (A20_RST)
   ) u_pin (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load_pin),
      .d     (wr_data[GATE_BIT]),
      .q     (a20_q)
   );

   // R1: first cycle out of reset shows the reset values
   p_reset_vals_r1: assert property (@(posedge clk)
      !rst_n |=> (a20_q == A20_RST && !ibf_q));
   // R2: while disabled the pin never changes
   p_disabled_pin_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |=> $stable(a20_q));

endmodule

// File: tb/a20_gate_seq_tb_top.sv
`timescale 1ns/1ps
module a20_gate_seq_tb_top;

   localparam int CLK_HALF = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en_set = 1'b0;
   logic       wr_stb = 1'b0;
   logic       wr_cmd = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       cpu_rd = 1'b0;
   logic       a20_q;
   logic       ibf_q;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   // bench model: 0 idle, 1 armed, 2 complete
   int   m_st  = 0;
   logic m_en  = 1'b0;
   logic m_a20 = 1'b1;
   logic m_ibf = 1'b0;

   always #(CLK_HALF) clk = ~clk;

   a20_gate_seq dut_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_set  (en_set),
      .wr_stb  (wr_stb),
      .wr_cmd  (wr_cmd),
      .wr_data (wr_data),
      .cpu_rd  (cpu_rd),
      .a20_q   (a20_q),
      .ibf_q   (ibf_q)
   );

   function automatic int nxt_state(input logic en, input int st,
                                    input logic c, input logic [7:0] d);
      if (!en) return 0;
      if (c && d == 8'hD1) return 1;
      if (st == 1 && !c) return 2;
      return 0;
   endfunction

   function automatic logic flags(input logic en, input int st,
                                  input logic c, input logic [7:0] d);
      if (!en) return 1'b1;
      if (c && d == 8'hD1) return 1'b0;
      if (st == 1 && !c) return 1'b0;
      if (st == 2 && c && d == 8'hFF) return 1'b0;
      return 1'b1;
   endfunction

   task automatic check(input string req, input logic got, input logic exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %b expected %b", req, got, exp);
      end
   endtask

   task automatic check_both(input string req);
      check({req, " a20"}, a20_q, m_a20);
      check({req, " ibf"}, ibf_q, m_ibf);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      m_st = 0; m_en = 1'b0; m_a20 = 1'b1; m_ibf = 1'b0;
   endtask

   task automatic host_wr(input logic c, input logic [7:0] d, input logic rd,
                          input string req);
      logic f;
      @(negedge clk);
      wr_stb = 1'b1; wr_cmd = c; wr_data = d; cpu_rd = rd;
      f = flags(m_en, m_st, c, d);
      if (m_en && m_st == 1 && !c) m_a20 = d[1];
      m_st = nxt_state(m_en, m_st, c, d);
      if (f) m_ibf = 1'b1;
      else if (rd) m_ibf = 1'b0;
      @(negedge clk);
      wr_stb = 1'b0; cpu_rd = 1'b0;
      check_both(req);
   endtask

   task automatic cpu_read(input string req);
      @(negedge clk);
      cpu_rd = 1'b1;
      m_ibf = 1'b0;
      @(negedge clk);
      cpu_rd = 1'b0;
      check({req, " ibf"}, ibf_q, m_ibf);
   endtask

   task automatic pulse_en();
      @(negedge clk);
      en_set = 1'b1;
      @(negedge clk);
      en_set = 1'b0;
      m_en = 1'b1;
   endtask

   initial begin
      #(CLK_HALF * 2 * 200000);
      if (!done) begin
         n_fail++;
         n_chk++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240607));
      do_reset();
      @(negedge clk);
      check_both("R1 reset");

      // R2: disabled decoder
      host_wr(1'b1, 8'hD1, 1'b0, "R2 disabled D1");
      host_wr(1'b0, 8'hDD, 1'b0, "R2 disabled data");
      cpu_read("R9 clear");

      // R3: enable, and same-cycle write is a disabled write
      @(negedge clk);
      en_set = 1'b1; wr_stb = 1'b1; wr_cmd = 1'b1; wr_data = 8'hD1;
      m_ibf = 1'b1; m_st = 0;
      @(negedge clk);
      en_set = 1'b0; wr_stb = 1'b0;
      m_en = 1'b1;
      check_both("R3 same-cycle write");
      cpu_read("R9 clear");

      // R4 / R5 clear and set
      host_wr(1'b1, 8'hD1, 1'b0, "R5 D1");
      host_wr(1'b0, 8'hDD, 1'b0, "R4 DDh clears");
      // R6 trailing FFh absorbed, second FFh flagged
      host_wr(1'b1, 8'hFF, 1'b0, "R6 trailing FF");
      host_wr(1'b1, 8'hFF, 1'b0, "R6 stray FF");
      cpu_read("R9 clear");
      // R7 doubled D1
      host_wr(1'b1, 8'hD1, 1'b0, "R7 D1 first");
      host_wr(1'b1, 8'hD1, 1'b0, "R7 D1 again");
      host_wr(1'b0, 8'h02, 1'b0, "R4 bit1 only");
      host_wr(1'b0, 8'hFD, 1'b0, "R10 data in complete");
      cpu_read("R9 clear");
      // R8 aborted sequence
      host_wr(1'b1, 8'hD1, 1'b0, "R8 D1");
      host_wr(1'b1, 8'h55, 1'b0, "R8 foreign cmd");
      host_wr(1'b0, 8'hDD, 1'b0, "R8 data after abort");
      // R9 write raising flag wins over same-cycle read
      host_wr(1'b0, 8'h00, 1'b1, "R9 set wins");
      cpu_read("R9 clear");
      // R10 other command in complete state
      host_wr(1'b1, 8'hD1, 1'b0, "R10 D1");
      host_wr(1'b0, 8'hDF, 1'b0, "R10 DFh sets");
      host_wr(1'b1, 8'h60, 1'b0, "R10 foreign in complete");
      host_wr(1'b0, 8'hDD, 1'b0, "R10 data in idle");
      cpu_read("R9 clear");
      // R3: extra enable pulse is harmless; reset drops enable
      pulse_en();
      host_wr(1'b1, 8'hD1, 1'b0, "R3 still enabled");
      host_wr(1'b0, 8'hDD, 1'b0, "R11 clear via seq");
      do_reset();
      @(negedge clk);
      check_both("R1 reset again");
      host_wr(1'b1, 8'hD1, 1'b0, "R3 disabled after reset");
      host_wr(1'b0, 8'hDD, 1'b0, "R3 no pin change");
      cpu_read("R9 clear");
      pulse_en();

      // random mix
      for (int i = 0; i < 3000; i++) begin
         int sel;
         logic c;
         logic [7:0] d;
         sel = int'($urandom_range(0, 9));
         c = $urandom_range(0, 1) == 1;
         case (sel)
            0, 1, 2: begin c = 1'b1; d = 8'hD1; end
            3, 4:    begin c = 1'b1; d = 8'hFF; end
            5:       d = 8'hDF;
            6:       d = 8'hDD;
            default: d = 8'($urandom());
         endcase
         if ($urandom_range(0, 7) == 0) cpu_read("R9 random read");
         else host_wr(c, d, $urandom_range(0, 5) == 0, "R4 R5 R6 R8 R11 random");
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

endmodule